// File: doc/BRIEF.md
# PCI Initiator Bus Request Controller

This block is the bus-ownership front end of a 32-bit PCI initiator. The user side asks for the bus with a single-cycle pulse. The block turns that pulse into a held, active-low request toward the central arbiter and watches the active-low grant coming back. When a grant meets an idle bus, the block issues a one-cycle transaction-start pulse and counts itself busy. It stays busy until the data-phase-active indication falls. A grant that arrives when nothing is pending, or while bus mastering is disabled, counts as bus parking and starts nothing.

Software enables bus mastering through a bit of the command register. That bit is written through a simple write-enable/data port and read back on a status pin. Reset clears the bit, so the initiator stays off until software sets it again. A self-configuration strobe raised together with the request pulse overrides a clear enable bit. It starts a combined initiator-and-target access to the block's own configuration space, and the self-access indication stays high until that transaction ends. While reset is low, the request pin's output enable is low, so the pad floats, and the grant is ignored.

All control and status pins are plain levels or single-cycle pulses. No stream interface exists here, so there is no back-pressure: a request pulse that cannot be accepted is dropped.

Top module: `pci_req_ctrl`

## Requirements
- R1: While `rst_n` is low, `req_oe` is 0 and `bme`, `xfer_start`, `park`, `busy` and `self_cfg_active` are all 0, even with `gnt_n` low and `usr_req` high. One clock after reset is released, `req_oe` is 1 and `req_n` is 1.
- R2: A clock edge with `cfg_we` high loads `cfg_wdata[2]` (the enable bit is bit 2) into the bus master enable bit. The bit is visible on `bme` after that edge. Reset clears it to 0.
- R3: With `bme` at 1, an idle block and nothing pending, a one-cycle `usr_req` pulse drives `req_n` to 0 from the next clock on, with `req_oe` at 1.
- R4: With `bme` at 0 and `usr_self_cfg` low, a `usr_req` pulse leaves no pending state and `req_n` stays 1. A request in the same cycle as a `cfg_we` write is judged by the value of `bme` before that write.
- R5: When a request is pending, `gnt_n` is 0 and `frame_n` and `irdy_n` are both 1, the next clock raises `xfer_start` for exactly one cycle. In that same cycle `busy` goes to 1 and `req_n` returns to 1.
- R6: While the grant is absent or the bus is not idle (`frame_n` or `irdy_n` at 0), a pending request is held, `req_n` stays 0 and no start is issued.
- R7: If `gnt_n` is 0 while the block is not busy and no permitted request is pending, `park` is 1 in the next cycle and no start is issued. `park` is 0 while busy.
- R8: A `usr_req` pulse together with `usr_self_cfg` high is accepted even when `bme` is 0. Its start raises `self_cfg_active`, which stays 1 until `busy` falls.
- R9: `busy` falls on the clock after `data_active` goes from 1 to 0. A `usr_req` pulse while `busy` is 1 is dropped and leaves `req_n` at 1.
- R10: After a start, `req_n` stays 1 until a new accepted request pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Command register write strobe |
| cfg_wdata | input | 16 | Command register write data; bit 2 is the bus master enable |
| bme | output | 1 | Read-back of the bus master enable bit |
| usr_req | input | 1 | One-cycle bus request pulse from the user side |
| usr_self_cfg | input | 1 | Self-configuration strobe, raised with `usr_req` |
| data_active | input | 1 | High while the data phase of a transaction runs |
| gnt_n | input | 1 | Active-low grant from the arbiter |
| frame_n | input | 1 | Active-low bus FRAME# as observed |
| irdy_n | input | 1 | Active-low bus IRDY# as observed |
| req_n | output | 1 | Active-low request toward the arbiter |
| req_oe | output | 1 | Output enable of the request pad; 0 means high impedance |
| xfer_start | output | 1 | One-cycle pulse when the bus is taken for a transaction |
| park | output | 1 | Bus is parked on this agent |
| busy | output | 1 | A transaction is in progress |
| self_cfg_active | output | 1 | The running transaction is a self-configuration access |

## Verification
Two collisions are provoked on purpose. In the first, the grant arrives in the same cycle as the user's request pulse. At that edge nothing is pending yet, so the expected result is one cycle of `park` followed by `xfer_start` on the next clock. In the second, a software write to the enable bit lands in the same cycle as a request pulse. The request must be judged by the old enable value, so a request that arrives with the enabling write is dropped, and one that arrives with the disabling write is accepted.

// File: rtl/pci_req_pkg.sv
package pci_req_pkg;
  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_BUSY = 1'b1
  } own_state_e;
endpackage

// File: rtl/pci_cmd_bit.sv
module pci_cmd_bit #(
  parameter int CMD_W   = 16,
  parameter int BME_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CMD_W-1:0] cfg_wdata,
  output logic             bme
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bme <= 1'b0;
    else if (cfg_we) bme <= cfg_wdata[BME_BIT];
  end

  AST_BME_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (bme == $past(cfg_wdata[BME_BIT]))); // R2
  AST_BME_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(bme)); // R2
endmodule

// File: rtl/pci_req_hold.sv
module pci_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic bme,
  input  logic busy,
  input  logic go,
  input  logic usr_req,
  input  logic usr_self_cfg,
  output logic pending,
  output logic self_pend
);
  logic accept;
  logic lose_permit;

  assign accept      = usr_req && !busy && !pending && (bme || usr_self_cfg);
  assign lose_permit = pending && !bme && !self_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      self_pend <= 1'b0;
    end else if (go || lose_permit) begin
      pending   <= 1'b0;
      self_pend <= 1'b0;
    end else if (accept) begin
      pending   <= 1'b1;
      self_pend <= usr_self_cfg;
    end
  end

  AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pending) |=> !pending); // R9
  AST_DROP_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !bme && !usr_self_cfg) |=> !pending); // R4
  AST_SELF_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    self_pend |-> pending); // R8
endmodule

// File: rtl/pci_own_fsm.sv
module pci_own_fsm
  import pci_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic self_pend,
  input  logic gnt_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic data_active,
  output logic go,
  output logic busy,
  output logic xfer_start,
  output logic park,
  output logic self_cfg_active
);
  own_state_e state;
  logic       granted;
  logic       bus_idle;
  logic       da_q;
  logic       xfer_end;

  assign granted  = !gnt_n;
  assign bus_idle = frame_n && irdy_n;
  assign go       = (state == OWN_IDLE) && pending && granted && bus_idle;
  assign xfer_end = (state == OWN_BUSY) && da_q && !data_active;
  assign busy     = (state == OWN_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= OWN_IDLE;
      xfer_start      <= 1'b0;
      park            <= 1'b0;
      self_cfg_active <= 1'b0;
      da_q            <= 1'b0;
    end else begin
      da_q       <= data_active;
      xfer_start <= go;
      park       <= (state == OWN_IDLE) && granted && !pending;
      case (state)
        OWN_IDLE: if (go) begin
          state           <= OWN_BUSY;
          self_cfg_active <= self_pend;
        end
        OWN_BUSY: if (xfer_end) begin
          state           <= OWN_IDLE;
          self_cfg_active <= 1'b0;
        end
        default: state <= OWN_IDLE;
      endcase
    end
  end

  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(!gnt_n && frame_n && irdy_n)); // R5
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R5
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> busy); // R5
  AST_PARK_NOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(park && xfer_start)); // R7
  AST_PARK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !park); // R7
  AST_SELF_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    self_cfg_active |-> busy); // R8
  AST_BUSY_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(da_q) && !$past(data_active))); // R9
endmodule

// File: rtl/pci_req_ctrl.sv
module pci_req_ctrl #(
  parameter int CMD_W   = 16,
  parameter int BME_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CMD_W-1:0] cfg_wdata,
  output logic             bme,
  input  logic             usr_req,
  input  logic             usr_self_cfg,
  input  logic             data_active,
  input  logic             gnt_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  output logic             req_n,
  output logic             req_oe,
  output logic             xfer_start,
  output logic             park,
  output logic             busy,
  output logic             self_cfg_active
);
  logic pending;
  logic self_pend;
  logic go;

  pci_cmd_bit #(.CMD_W(CMD_W), .BME_BIT(BME_BIT)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .bme(bme)
  );

  pci_req_hold u_hold (
    .clk(clk), .rst_n(rst_n), .bme(bme), .busy(busy), .go(go),
    .usr_req(usr_req), .usr_self_cfg(usr_self_cfg),
    .pending(pending), .self_pend(self_pend)
  );

  pci_own_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pending(pending), .self_pend(self_pend),
    .gnt_n(gnt_n), .frame_n(frame_n), .irdy_n(irdy_n), .data_active(data_active),
    .go(go), .busy(busy), .xfer_start(xfer_start), .park(park),
    .self_cfg_active(self_cfg_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_oe <= 1'b0;
    else        req_oe <= 1'b1;
  end

  assign req_n = !pending;

  AST_REQ_FLOATS_IN_RST: assert property (@(posedge clk)
    !rst_n |-> !req_oe); // R1
  AST_REQ_HELD_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && gnt_n && bme) |=> !req_n); // R6
  AST_REQ_DROPS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> req_n); // R10
  AST_REQ_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_n && !usr_req) |=> req_n); // R10
endmodule

// File: tb/pci_req_ctrl_test.sv
module pci_req_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        usr_req = 1'b0;
  logic        usr_self_cfg = 1'b0;
  logic        data_active = 1'b0;
  logic        gnt_n = 1'b1;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        bme, req_n, req_oe, xfer_start, park, busy, self_cfg_active;

  int tests_run = 0;
  int tests_failed = 0;

  always #10 clk = ~clk;

  pci_req_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .bme(bme),
    .usr_req(usr_req), .usr_self_cfg(usr_self_cfg), .data_active(data_active),
    .gnt_n(gnt_n), .frame_n(frame_n), .irdy_n(irdy_n), .req_n(req_n),
    .req_oe(req_oe), .xfer_start(xfer_start), .park(park), .busy(busy),
    .self_cfg_active(self_cfg_active)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_bme(input logic v);
    cfg_we = 1'b1; cfg_wdata = '0; cfg_wdata[2] = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req(input logic self_cfg);
    usr_req = 1'b1; usr_self_cfg = self_cfg;
    step();
    usr_req = 1'b0;
  endtask

  task automatic finish_xfer();
    data_active = 1'b1;
    step();
    data_active = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; gnt_n = 1'b0; usr_req = 1'b1;
    step(); step();
    check("R1 req_oe in reset", req_oe, 1'b0);
    check("R1 bme in reset", bme, 1'b0);
    check("R1 park in reset", park, 1'b0);
    check("R1 start in reset", xfer_start, 1'b0);
    check("R1 busy in reset", busy, 1'b0);
    check("R1 self in reset", self_cfg_active, 1'b0);
    gnt_n = 1'b1; usr_req = 1'b0; rst_n = 1'b1;
    step();
    check("R1 req_oe after reset", req_oe, 1'b1);
    check("R1 req_n after reset", req_n, 1'b1);
  endtask

  task automatic t_bme();
    write_bme(1'b1);
    check("R2 bme set", bme, 1'b1);
    step();
    check("R2 bme held", bme, 1'b1);
    write_bme(1'b0);
    check("R2 bme cleared", bme, 1'b0);
  endtask

  task automatic t_drop_disabled();
    pulse_req(1'b0);
    check("R4 req_n with bme clear", req_n, 1'b1);
    step();
    check("R4 no pending later", req_n, 1'b1);
    // request with the enabling write: old value 0 applies
    usr_req = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h0004;
    step();
    usr_req = 1'b0; cfg_we = 1'b0;
    check("R4 same-cycle write drops req", req_n, 1'b1);
    check("R2 bme after write", bme, 1'b1);
    // request with the disabling write: old value 1 applies
    usr_req = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h0000;
    step();
    usr_req = 1'b0; cfg_we = 1'b0;
    check("R4 same-cycle clear accepts req", req_n, 1'b0);
    step();
    check("R4 pending lost once bme clear", req_n, 1'b1);
    write_bme(1'b1);
  endtask

  task automatic t_basic();
    pulse_req(1'b0);
    check("R3 req_n low", req_n, 1'b0);
    check("R3 req_oe high", req_oe, 1'b1);
    step();
    check("R6 held without grant", req_n, 1'b0);
    gnt_n = 1'b0; frame_n = 1'b0;
    step();
    check("R6 no start on busy bus", xfer_start, 1'b0);
    check("R6 req held on busy bus", req_n, 1'b0);
    gnt_n = 1'b1; frame_n = 1'b1;
    step();
    check("R6 req held after grant withdrawn", req_n, 1'b0);
    gnt_n = 1'b0;
    step();
    gnt_n = 1'b1;
    check("R5 start pulse", xfer_start, 1'b1);
    check("R5 busy", busy, 1'b1);
    check("R5 req_n released", req_n, 1'b1);
    check("R8 no self flag", self_cfg_active, 1'b0);
    pulse_req(1'b0);
    check("R5 start one cycle", xfer_start, 1'b0);
    check("R9 req during busy dropped", req_n, 1'b1);
    step();
    check("R9 still busy", busy, 1'b1);
    finish_xfer();
    check("R9 busy ends", busy, 1'b0);
    step();
    check("R10 no re-request", req_n, 1'b1);
  endtask

  task automatic t_park();
    gnt_n = 1'b0;
    step();
    check("R7 park when idle", park, 1'b1);
    check("R7 no start on park", xfer_start, 1'b0);
    gnt_n = 1'b1;
    step();
    check("R7 park ends", park, 1'b0);
    write_bme(1'b0);
    gnt_n = 1'b0; usr_req = 1'b1;
    step();
    usr_req = 1'b0;
    step();
    check("R7 park with bme clear", park, 1'b1);
    check("R7 no start bme clear", xfer_start, 1'b0);
    gnt_n = 1'b1;
    write_bme(1'b1);
    // request and grant in the same cycle
    usr_req = 1'b1; gnt_n = 1'b0;
    step();
    usr_req = 1'b0;
    check("R7 collide park first", park, 1'b1);
    check("R7 collide no start yet", xfer_start, 1'b0);
    step();
    gnt_n = 1'b1;
    check("R5 collide start next", xfer_start, 1'b1);
    check("R7 collide park gone", park, 1'b0);
    finish_xfer();
  endtask

  task automatic t_self();
    write_bme(1'b0);
    pulse_req(1'b1);
    usr_self_cfg = 1'b1;
    check("R8 self req accepted", req_n, 1'b0);
    gnt_n = 1'b0;
    step();
    gnt_n = 1'b1;
    check("R8 self start", xfer_start, 1'b1);
    check("R8 self active", self_cfg_active, 1'b1);
    step();
    check("R8 self held", self_cfg_active, 1'b1);
    finish_xfer();
    usr_self_cfg = 1'b0;
    check("R8 self cleared", self_cfg_active, 1'b0);
    check("R9 self busy cleared", busy, 1'b0);
  endtask

  initial begin
    step();
    t_reset();
    t_bme();
    t_drop_disabled();
    t_basic();
    t_park();
    t_self();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #(20 * 20000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule